// File: doc/BRIEF.md
# Multicycle Register-Machine Core with Zero-Test Copy

A small processor core that runs one instruction at a time through a sequence of clocked states: fetch, decode, execute, and then a memory access, a register writeback or a branch update, depending on the instruction class. One word-addressed memory holds both program and data. There are eight 32-bit general registers; register 0 reads as zero. The core executes add, load word, store word, branch-if-equal, halt, and a zero-test copy. The zero-test copy inspects its second register: when that register is zero, it receives the first register's value; otherwise it is cleared.

A testbench, or a loader, fills the memory through a preload port while the core is held in reset. It then releases reset and waits for the halt output. A debug read port selects any register, and the program counter is always visible. Both ports let results be read back without extra instructions.

Top module: `mcyc_core`

## Requirements
- R1: While reset is asserted the program counter is 0, halt_o is low and every register reads 0.
- R2: Instruction fields: opcode in bits 24..22, first register index (rA) in bits 21..19, second register index (rB) in bits 18..16. Opcodes: 0 add, 2 load, 3 store, 4 branch-if-equal, 6 halt, 7 zero-test copy. Add writes rA+rB (modulo 2^32) to the register indexed by bits 2..0.
- R3: Load writes memory[rA + sext(bits 15..0)] into rB, with the address taken modulo the memory depth.
- R4: Store writes rB to memory[rA + sext(bits 15..0)] and changes no register.
- R5: Branch-if-equal sets PC to PC+1+sext(bits 15..0) when rA equals rB, and to PC+1 otherwise. Negative offsets are allowed.
- R6: Zero-test copy writes rA into rB when rB is zero, and writes zero into rB otherwise. Bits 15..0 of this instruction have no effect.
- R7: Register 0 always reads as zero, and writes to it are dropped.
- R8: Load takes 5 clock cycles. Add, store, branch-if-equal and zero-test copy take 4 each.
- R9: Halt raises halt_o two cycles after its fetch begins. PC then points to the word after the halt, and halt_o and the PC stay frozen until reset.
- R10: Opcodes 1 and 5 are no-ops of 2 cycles that change no register and no memory word.
- R11: A preload write (pre_we_i high) stores pre_data_i at pre_addr_i on the rising clock edge, including while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the core state |
| pre_we_i | input | 1 | Memory preload write enable |
| pre_addr_i | input | $clog2(MEM_WORDS) | Memory preload word address |
| pre_data_i | input | 32 | Memory preload data |
| dbg_sel_i | input | 3 | Register index for the debug read port |
| dbg_reg_o | output | 32 | Value of the selected register |
| dbg_pc_o | output | $clog2(MEM_WORDS) | Current program counter |
| halt_o | output | 1 | High once a halt instruction has been executed |

## Verification
The hardest case to reach is the zero-test copy across every pairing of register indices and zero or nonzero operands. This includes rA equal to rB and the r0 source or destination. Each of these cases needs registers loaded with chosen values first. The bench generates one short program per case (two loads, the copy with varied junk in its low half, then halt) for all 64 index pairs and both operand states. It derives the expected register contents arithmetically, and also checks the total cycle count to halt. A countdown loop with a backward branch covers negative branch offsets and repeated branch outcomes within a single run.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned REG_IDX_W = 3;
  localparam int unsigned NUM_REGS  = 1 << REG_IDX_W;

  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_LW   = 3'd2;
  localparam logic [2:0] OP_SW   = 3'd3;
  localparam logic [2:0] OP_BEQ  = 3'd4;
  localparam logic [2:0] OP_HALT = 3'd6;
  localparam logic [2:0] OP_ZCPY = 3'd7;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB, ST_BR, ST_HALT
  } state_e;

  typedef struct packed {
    logic ir_we;
    logic pc_step;
    logic opnd_we;
    logic res_we;
    logic mdr_we;
    logic dmem_we;
    logic rf_we;
    logic br_en;
    logic addr_data;
    logic halted;
  } ctrl_t;

  function automatic logic [WORD_W-1:0] sext16(input logic [15:0] v);
    return {{(WORD_W-16){v[15]}}, v};
  endfunction
endpackage

// File: rtl/mcyc_regfile.sv
module mcyc_regfile
  import mcyc_pkg::*;
#(
  parameter int unsigned NREG = NUM_REGS,
  parameter int unsigned DW   = WORD_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [$clog2(NREG)-1:0] waddr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [$clog2(NREG)-1:0] raddr_a_i,
  output logic [DW-1:0]           rdata_a_o,
  input  logic [$clog2(NREG)-1:0] raddr_b_i,
  output logic [DW-1:0]           rdata_b_o,
  input  logic [$clog2(NREG)-1:0] raddr_d_i,
  output logic [DW-1:0]           rdata_d_o
);
  localparam int unsigned IW = $clog2(NREG);

  logic [NREG*DW-1:0] flat;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign flat[DW-1:0] = '0;
    end else begin : g_store
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             q <= '0;
        else if (we_i && waddr_i == IW'(g))      q <= wdata_i;
      end
      assign flat[g*DW +: DW] = q;
    end
  end

  assign rdata_a_o = flat[raddr_a_i*DW +: DW];
  assign rdata_b_o = flat[raddr_b_i*DW +: DW];
  assign rdata_d_o = flat[raddr_d_i*DW +: DW];
endmodule

// File: rtl/mcyc_mem.sv
module mcyc_mem #(
  parameter int unsigned WORDS = 64,
  parameter int unsigned DW    = 32
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(WORDS)-1:0] waddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [$clog2(WORDS)-1:0] raddr_i,
  output logic [DW-1:0]            rdata_o
);
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] op_i,
  output state_e     state_o,
  output ctrl_t      ctrl_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        unique case (op_i)
          OP_ADD, OP_LW, OP_SW, OP_BEQ, OP_ZCPY: state_d = ST_EXEC;
          OP_HALT:                                state_d = ST_HALT;
          default:                                state_d = ST_FETCH; // unused opcode: no-op
        endcase
      end
      ST_EXEC: begin
        if (op_i == OP_LW || op_i == OP_SW) state_d = ST_MEM;
        else if (op_i == OP_BEQ)            state_d = ST_BR;
        else                                state_d = ST_WB;
      end
      ST_MEM:  state_d = (op_i == OP_LW) ? ST_WB : ST_FETCH;
      ST_WB:   state_d = ST_FETCH;
      ST_BR:   state_d = ST_FETCH;
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  always_comb begin
    ctrl_o           = '0;
    ctrl_o.ir_we     = (state_q == ST_FETCH);
    ctrl_o.pc_step   = (state_q == ST_FETCH);
    ctrl_o.opnd_we   = (state_q == ST_DECODE);
    ctrl_o.res_we    = (state_q == ST_EXEC);
    ctrl_o.mdr_we    = (state_q == ST_MEM) && (op_i == OP_LW);
    ctrl_o.dmem_we   = (state_q == ST_MEM) && (op_i == OP_SW);
    ctrl_o.rf_we     = (state_q == ST_WB);
    ctrl_o.br_en     = (state_q == ST_BR);
    ctrl_o.addr_data = (state_q == ST_MEM);
    ctrl_o.halted    = (state_q == ST_HALT);
  end

  assign state_o = state_q;
endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
  import mcyc_pkg::*;
#(
  parameter int unsigned MEM_WORDS = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         pre_we_i,
  input  logic [$clog2(MEM_WORDS)-1:0] pre_addr_i,
  input  logic [WORD_W-1:0]            pre_data_i,
  input  logic [REG_IDX_W-1:0]         dbg_sel_i,
  output logic [WORD_W-1:0]            dbg_reg_o,
  output logic [$clog2(MEM_WORDS)-1:0] dbg_pc_o,
  output logic                         halt_o
);
  localparam int unsigned AW = $clog2(MEM_WORDS);
  localparam int unsigned DW = WORD_W;

  state_e state;
  ctrl_t  c;

  logic [AW-1:0] pc_q;
  logic [DW-1:0] ir_q, a_q, b_q, res_q, mdr_q;
  logic          eq_q;

  logic [2:0]           op;
  logic [REG_IDX_W-1:0] ra, rb, rd;
  logic [DW-1:0]        off, rf_a, rf_b, exec_res, mem_rdata, rf_wdata;
  logic [REG_IDX_W-1:0] rf_waddr;
  logic                 rf_we;
  logic                 mem_we;
  logic [AW-1:0]        mem_waddr, mem_raddr;
  logic [DW-1:0]        mem_wdata;

  assign op  = ir_q[24:22];
  assign ra  = ir_q[21:19];
  assign rb  = ir_q[18:16];
  assign rd  = ir_q[2:0];
  assign off = sext16(ir_q[15:0]);

  logic unused_bits;
  assign unused_bits = ^{ir_q[31:25], ir_q[15:3], res_q[DW-1:AW]};

  mcyc_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .state_o (state),
    .ctrl_o  (c)
  );

  // preload has priority over core stores
  assign mem_we    = pre_we_i | c.dmem_we;
  assign mem_waddr = pre_we_i ? pre_addr_i : res_q[AW-1:0];
  assign mem_wdata = pre_we_i ? pre_data_i : b_q;
  assign mem_raddr = c.addr_data ? res_q[AW-1:0] : pc_q;

  mcyc_mem #(.WORDS(MEM_WORDS), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  assign rf_we    = c.rf_we;
  assign rf_waddr = (op == OP_ADD) ? rd : rb;
  assign rf_wdata = (op == OP_LW) ? mdr_q : res_q;

  mcyc_regfile #(.NREG(NUM_REGS), .DW(DW)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata),
    .raddr_a_i (ra),
    .rdata_a_o (rf_a),
    .raddr_b_i (rb),
    .rdata_b_o (rf_b),
    .raddr_d_i (dbg_sel_i),
    .rdata_d_o (dbg_reg_o)
  );

  always_comb begin
    unique case (op)
      OP_ADD:        exec_res = a_q + b_q;
      OP_LW, OP_SW:  exec_res = a_q + off;
      OP_BEQ:        exec_res = {{(DW-AW){1'b0}}, pc_q} + off; // pc already stepped
      OP_ZCPY:       exec_res = (b_q == '0) ? a_q : '0;
      default:       exec_res = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
      mdr_q <= '0;
      eq_q  <= 1'b0;
    end else begin
      if (c.ir_we)   ir_q <= mem_rdata;
      if (c.pc_step) pc_q <= pc_q + 1'b1;
      if (c.opnd_we) begin
        a_q <= rf_a;
        b_q <= rf_b;
      end
      if (c.res_we) begin
        res_q <= exec_res;
        eq_q  <= (a_q == b_q);
      end
      if (c.mdr_we)         mdr_q <= mem_rdata;
      if (c.br_en && eq_q)  pc_q  <= res_q[AW-1:0];
    end
  end

  assign dbg_pc_o = pc_q;
  assign halt_o   = c.halted;
endmodule

// File: rtl/mcyc_core_chk.sv
module mcyc_core_chk
  import mcyc_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 halt_o,
  input state_e               state_i,
  input logic [2:0]           op_i,
  input logic [AW-1:0]        pc_i,
  input logic                 rf_we_i,
  input logic [REG_IDX_W-1:0] rf_waddr_i,
  input logic [REG_IDX_W-1:0] rb_i
);
  a_r8_fetch_to_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_FETCH |=> state_i == ST_DECODE);

  a_r8_load_extra_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_MEM && op_i == OP_LW) |=> state_i == ST_WB);

  a_r8_store_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_MEM && op_i == OP_SW) |=> state_i == ST_FETCH);

  a_r4_store_no_rf_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_MEM && op_i == OP_SW) |=> !rf_we_i);

  a_r5_pc_moves_only_fetch_or_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(state_i == ST_FETCH || state_i == ST_BR) |=> $stable(pc_i));

  a_r9_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o && $stable(pc_i));

  a_r6_copy_targets_rb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_i && op_i == OP_ZCPY) |-> rf_waddr_i == rb_i);
endmodule

bind mcyc_core mcyc_core_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .halt_o     (halt_o),
  .state_i    (state),
  .op_i       (op),
  .pc_i       (pc_q),
  .rf_we_i    (rf_we),
  .rf_waddr_i (rf_waddr),
  .rb_i       (rb)
);

// File: tb/mcyc_core_test.sv
module mcyc_core_test;
  localparam int WORDS = 64;
  localparam int AW    = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          pre_we_i = 1'b0;
  logic [AW-1:0] pre_addr_i = '0;
  logic [31:0]   pre_data_i = '0;
  logic [2:0]    dbg_sel_i = '0;
  logic [31:0]   dbg_reg_o;
  logic [AW-1:0] dbg_pc_o;
  logic          halt_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc;
  logic [31:0] prog [WORDS];

  always #4 clk_i = ~clk_i;

  mcyc_core #(.MEM_WORDS(WORDS)) uut (
    .clk_i, .rst_ni, .pre_we_i, .pre_addr_i, .pre_data_i,
    .dbg_sel_i, .dbg_reg_o, .dbg_pc_o, .halt_o
  );

  function automatic logic [31:0] enc(int op, int ra, int rb, logic [15:0] lo);
    return {7'd0, op[2:0], ra[2:0], rb[2:0], lo};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(int idx, output logic [31:0] v);
    dbg_sel_i = idx[2:0];
    #1;
    v = dbg_reg_o;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < WORDS; i++) prog[i] = enc(6, 0, 0, 16'h0);
  endtask

  // preload under reset, release, count cycles to halt
  task automatic run(bit chk_reset);
    logic [31:0] v;
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < WORDS; i++) begin
      pre_we_i = 1'b1;
      pre_addr_i = AW'(i);
      pre_data_i = prog[i];
      @(negedge clk_i);
    end
    pre_we_i = 1'b0;
    if (chk_reset) begin
      check("R1 halt in reset", {31'd0, halt_o}, 32'd0);
      check("R1 pc in reset", {26'd0, dbg_pc_o}, 32'd0);
      for (int r = 0; r < 8; r++) begin
        rd(r, v);
        check("R1 reg in reset", v, 32'd0);
      end
    end
    rst_ni = 1'b1;
    cyc = 0;
    while (1) begin
      @(posedge clk_i);
      cyc++;
      #1;
      if (halt_o) break;
      if (cyc > 3000) begin
        n_run++;
        n_fail++;
        $display("FAIL R8 no halt actual=%0d expected<=3000", cyc);
        break;
      end
    end
    @(negedge clk_i);
  endtask

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, a_val, b_val, a_eff, b_eff, exp_rb;
    logic [31:0] add_a [5];
    logic [31:0] add_b [5];
    logic [AW-1:0] pc_h;
    add_a = '{32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd0, 32'hDEAD_BEEF};
    add_b = '{32'd2, 32'd1,         32'h7FFF_FFFF, 32'd0, 32'h1234_5678};

    // R2 add sweep, with R1 reset check on the first run
    for (int k = 0; k < 5; k++) begin
      clear_prog();
      prog[0] = enc(2, 0, 1, 16'd40);
      prog[1] = enc(2, 0, 2, 16'd41);
      prog[2] = enc(0, 1, 2, 16'd3);
      prog[40] = add_a[k];
      prog[41] = add_b[k];
      run(k == 0);
      rd(3, v);
      check("R2 add sum", v, add_a[k] + add_b[k]);
      check("R8 add cycles", cyc, 32'd16);
      check("R9 pc after halt", {26'd0, dbg_pc_o}, 32'd4);
    end

    // R6 zero-test copy, all index pairs, zero and nonzero rB
    for (int ra = 0; ra < 8; ra++)
      for (int rb = 0; rb < 8; rb++)
        for (int z = 0; z < 2; z++) begin
          a_val = 32'h1000_0000 + ra * 16 + rb;
          b_val = (z == 0) ? 32'd0 : 32'h8000_0001 + rb;
          clear_prog();
          prog[0] = enc(2, 0, ra, 16'd40);
          prog[1] = enc(2, 0, rb, 16'd41);
          prog[2] = enc(7, ra, rb, 16'hFFFF ^ 16'(ra * 8 + rb));
          prog[40] = a_val;
          prog[41] = b_val;
          run(0);
          a_eff = (ra == 0) ? 32'd0 : ((ra == rb) ? b_val : a_val);
          b_eff = (rb == 0) ? 32'd0 : b_val;
          exp_rb = (rb == 0) ? 32'd0 : ((b_eff == 0) ? a_eff : 32'd0);
          rd(rb, v);
          check("R6 copy result", v, exp_rb);
          if (ra != rb) begin
            rd(ra, v);
            check("R6 source kept", v, a_eff);
          end
          check("R8 copy cycles", cyc, 32'd16);
        end

    // R3/R4 store via base with negative offset, then load back
    clear_prog();
    prog[0] = enc(2, 0, 1, 16'd40);
    prog[1] = enc(2, 0, 2, 16'd41);
    prog[2] = enc(3, 2, 1, 16'hFFFD);
    prog[3] = enc(2, 0, 3, 16'd47);
    prog[40] = 32'hCAFE_F00D;
    prog[41] = 32'd50;
    prog[47] = 32'd0;
    run(0);
    rd(3, v); check("R3 load of stored word", v, 32'hCAFE_F00D);
    rd(1, v); check("R4 store keeps rB", v, 32'hCAFE_F00D);
    rd(2, v); check("R4 store keeps rA", v, 32'd50);
    check("R8 lw/sw cycles", cyc, 32'd21);

    // R3 address wraps modulo memory depth: 60 + 10 -> 6
    clear_prog();
    prog[0] = enc(2, 0, 1, 16'd40);
    prog[1] = enc(2, 1, 2, 16'd10);
    prog[6] = 32'h0BAD_F00D;
    prog[40] = 32'd60;
    run(0);
    rd(2, v); check("R3 wrapped load", v, 32'h0BAD_F00D);

    // R5 branch taken / not taken
    for (int t = 0; t < 2; t++) begin
      clear_prog();
      prog[0] = enc(2, 0, 1, 16'd40);
      prog[1] = enc(2, 0, 2, 16'd41);
      prog[2] = enc(4, 1, 2, 16'd2);
      prog[3] = enc(2, 0, 3, 16'd42);
      prog[4] = enc(2, 0, 4, 16'd43);
      prog[40] = 32'd9;
      prog[41] = (t == 0) ? 32'd9 : 32'd10;
      prog[42] = 32'd111;
      prog[43] = 32'd222;
      run(0);
      rd(3, v); check("R5 skipped/executed r3", v, (t == 0) ? 32'd0 : 32'd111);
      rd(4, v); check("R5 skipped/executed r4", v, (t == 0) ? 32'd0 : 32'd222);
      check("R8 beq cycles", cyc, (t == 0) ? 32'd16 : 32'd26);
      check("R9 pc after halt", {26'd0, dbg_pc_o}, 32'd6);
    end

    // R5 countdown loop with backward branch
    clear_prog();
    prog[0] = enc(2, 0, 1, 16'd40);
    prog[1] = enc(2, 0, 2, 16'd41);
    prog[2] = enc(0, 1, 2, 16'd1);
    prog[3] = enc(4, 1, 0, 16'd1);
    prog[4] = enc(4, 0, 0, 16'hFFFD);
    prog[40] = 32'd3;
    prog[41] = 32'hFFFF_FFFF;
    run(0);
    rd(1, v); check("R5 loop counter", v, 32'd0);
    check("R5 loop cycles", cyc, 32'd44);
    pc_h = dbg_pc_o;
    check("R9 pc after loop halt", {26'd0, pc_h}, 32'd6);
    repeat (8) @(negedge clk_i);
    check("R9 halt held", {31'd0, halt_o}, 32'd1);
    check("R9 pc frozen", {26'd0, dbg_pc_o}, {26'd0, pc_h});

    // R10 unused opcodes
    clear_prog();
    prog[0] = enc(2, 0, 1, 16'd40);
    prog[1] = enc(1, 1, 1, 16'd1);
    prog[2] = enc(5, 1, 1, 16'd1);
    prog[40] = 32'd77;
    run(0);
    rd(1, v); check("R10 reg untouched", v, 32'd77);
    check("R10 no-op cycles", cyc, 32'd11);
    check("R10 pc", {26'd0, dbg_pc_o}, 32'd4);

    // R7 writes to r0 dropped
    clear_prog();
    prog[0] = enc(2, 0, 1, 16'd40);
    prog[1] = enc(0, 1, 1, 16'd0);
    prog[2] = enc(0, 0, 1, 16'd2);
    prog[40] = 32'd5;
    run(0);
    rd(0, v); check("R7 r0 zero", v, 32'd0);
    rd(2, v); check("R7 r0 read as zero", v, 32'd5);
    check("R8 r0 program cycles", cyc, 32'd15);

    // R11 preload lands while in reset: data word used by a later load
    clear_prog();
    prog[0] = enc(2, 0, 5, 16'd63);
    prog[63] = 32'h5A5A_A5A5;
    run(0);
    rd(5, v); check("R11 preloaded word", v, 32'h5A5A_A5A5);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule